// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit device virtual address into a physical address. A request carries the virtual address and an access type (read or write). With paging switched on, the block first looks in a four-entry fully associative translation cache. On a miss it reads a directory entry from memory, then a second-level entry, and returns the physical page joined to the page offset together with eight page flag bits. If either entry is absent, or the page forbids the requested access, it returns a fault that carries the access type. With paging switched off, the address passes through unchanged and no memory read takes place.

The directory base and the paging enable come in as plain inputs from a register block elsewhere. Table entries are fetched over a simple read port that has at most one read outstanding: a one-cycle request strobe with an address, then a data strobe some cycles later. Software that edits the tables uses two inputs to keep the cache coherent. One drops every cached mapping. The other drops only the mapping for one virtual page number.

Control sits in one state machine:
- IDLE accepts a request and goes to RESP when the address passes through or hits the cache. On a miss it goes to DIR_REQ.
- DIR_REQ issues the directory read and goes to DIR_WAIT.
- DIR_WAIT waits for data. It goes to PTE_REQ if the entry is present, or to RESP with a fault if it is not.
- PTE_REQ issues the second-level read and goes to PTE_WAIT.
- PTE_WAIT waits for data and goes to RESP.
- RESP presents the response for one cycle and returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: On a cache miss with paging enabled, the first memory read goes to dir_base + 4 × vaddr[31:22].
- R2: A directory entry with bit 0 clear gives a fault response after exactly one memory read. No second-level read is issued.
- R3: The second read goes to (directory entry with bits [11:0] cleared) + 4 × vaddr[21:12].
- R4: A second-level entry with bit 0 clear gives a fault response after two memory reads.
- R5: On success, rsp_paddr = {entry[31:12], vaddr[11:0]} and rsp_flags = entry[8:1].
- R6: A read needs entry bit 1, and a write needs entry bit 2. A missing permission gives a fault. rsp_write always echoes the request's access type.
- R7: With paging_en low, rsp_paddr equals the request address, rsp_flags is 0 and rsp_fault is 0. No memory read is issued, and the response comes in the cycle after acceptance.
- R8: A cache hit responds in the cycle after acceptance and issues no memory read. A page whose second-level entry is present is cached even when its access faults, and a later hit applies the permission check again.
- R9: The cache holds 4 mappings, and each fill goes to the next slot in round-robin order. After a fifth distinct page is filled, the first-filled page misses.
- R10: A one-cycle pulse on flush_all invalidates every cached mapping.
- R11: A pulse on flush_one invalidates only the mapping whose virtual page number equals flush_vpn. Other mappings still hit, and the next access to the flushed page walks the current table contents.
- R12: After reset, req_ready is 1 and rsp_valid and mem_rd_req are 0. rsp_valid is high for one cycle per request. A fault response has rsp_paddr and rsp_flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| paging_en | input | 1 | Translation on (1) or pass-through (0) |
| dir_base | input | 32 | Byte address of the directory |
| flush_all | input | 1 | Invalidate the whole cache |
| flush_one | input | 1 | Invalidate the mapping for flush_vpn |
| flush_vpn | input | 20 | Virtual page number to invalidate |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request (IDLE) |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_req | output | 1 | One-cycle table read strobe |
| mem_rd_addr | output | 32 | Table entry byte address |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Table entry returned |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_flags | output | 8 | Entry bits [8:1] (0 on fault or pass-through) |
| rsp_fault | output | 1 | Page fault |
| rsp_write | output | 1 | Access type of the answered request |

## Verification
The assertions assume four things about the block's environment:
- mem_rd_valid arrives only after a read strobe and at least one cycle later.
- req_valid is raised only while req_ready is high.
- dir_base stays fixed during a walk.
- Neither flush input pulses while a walk is in flight.

The stimulus drives each request from IDLE and waits for its response before sending the next. It changes dir_base only in reset and pulses flushes only between requests. Its memory model answers a read strobe two cycles later.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = VA_W - OFF_W;
    localparam int FLAG_W = 8;
    localparam int ENT_B  = 2;            // log2 of the entry size in bytes
    localparam int FLAG_RD = 0;           // entry bit 1
    localparam int FLAG_WR = 1;           // entry bit 2

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [FLAG_W-1:0] flags;
    } tlb_data_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_PTE_REQ,
        S_PTE_WAIT,
        S_RESP
    } walk_state_t;
endpackage

// File: rtl/ptw_tlb.sv
module ptw_tlb
    import ptw_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output tlb_data_t        lk_data,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  tlb_data_t        fill_data,
    input  logic             flush_all,
    input  logic             flush_one,
    input  logic [VPN_W-1:0] flush_vpn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] drop;
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    tlb_data_t          data_q [ENTRIES];
    logic [PTR_W-1:0]   ptr_q;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
            assign drop[g]  = flush_all || (flush_one && (tag_q[g] == flush_vpn));
        end
    endgenerate

    assign lk_hit = |match;

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_data = data_q[i];
            end
        end
    end

    // valid bits and replacement pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else begin
            if (fill_en) begin
                valid_q[ptr_q] <= 1'b1;
                ptr_q          <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            end
            for (int i = 0; i < ENTRIES; i++) begin
                if (drop[i]) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    // tag and payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[ptr_q]  <= fill_vpn;
            data_q[ptr_q] <= fill_data;
        end
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R8

    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0)); // R10

    generate
        if (ENTRIES > 1) begin : g_rr_chk
            AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
                fill_en |=> (ptr_q != $past(ptr_q))); // R9
        end
    endgenerate
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
    import ptw_pkg::*;
(
    input  logic              present,
    input  logic [FLAG_W-1:0] flags,
    input  logic              is_write,
    output logic              fault
);
    logic allowed;

    always_comb begin
        allowed = is_write ? flags[FLAG_WR] : flags[FLAG_RD];
        fault   = !present || !allowed;
    end
endmodule

// File: rtl/ptw_walk.sv
module ptw_walk
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic [VA_W-1:0]   dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              lk_hit,
    input  tlb_data_t         lk_data,
    output logic              fill_en,
    output logic [VPN_W-1:0]  fill_vpn,
    output tlb_data_t         fill_data,
    output logic              mem_rd_req,
    output logic [VA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [VA_W-1:0]   mem_rd_data,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [FLAG_W-1:0] rsp_flags,
    output logic              rsp_fault,
    output logic              rsp_write
);
    localparam int PAD_W = VA_W - IDX_W - ENT_B;

    walk_state_t        state_q, state_d;
    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic [PPN_W-1:0]   dir_q;
    logic [VA_W-1:0]    paddr_q;
    logic [FLAG_W-1:0]  flags_q;
    logic               fault_q;

    logic [VA_W-1:0]    dir_addr;
    logic [VA_W-1:0]    pte_addr;
    logic               chk_present;
    logic [FLAG_W-1:0]  chk_flags;
    logic               chk_write;
    logic               chk_fault;
    logic               unused_bits;

    assign unused_bits = ^mem_rd_data[OFF_W-1:FLAG_W+1];

    assign dir_addr = dir_base +
        {{PAD_W{1'b0}}, va_q[VA_W-1:VA_W-IDX_W], {ENT_B{1'b0}}};
    assign pte_addr = {dir_q, {OFF_W{1'b0}}} +
        {{PAD_W{1'b0}}, va_q[VA_W-IDX_W-1:OFF_W], {ENT_B{1'b0}}};

    // permission source: cached mapping in IDLE, fetched entry otherwise
    always_comb begin
        if (state_q == S_IDLE) begin
            chk_present = 1'b1;
            chk_flags   = lk_data.flags;
            chk_write   = req_write;
        end else begin
            chk_present = mem_rd_data[0];
            chk_flags   = mem_rd_data[FLAG_W:1];
            chk_write   = wr_q;
        end
    end

    ptw_perm i_perm (
        .present  (chk_present),
        .flags    (chk_flags),
        .is_write (chk_write),
        .fault    (chk_fault)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (!paging_en || lk_hit) state_d = S_RESP;
                    else                      state_d = S_DIR_REQ;
                end
            end
            S_DIR_REQ:  state_d = S_DIR_WAIT;
            S_DIR_WAIT: begin
                if (mem_rd_valid) begin
                    state_d = mem_rd_data[0] ? S_PTE_REQ : S_RESP;
                end
            end
            S_PTE_REQ:  state_d = S_PTE_WAIT;
            S_PTE_WAIT: begin
                if (mem_rd_valid) state_d = S_RESP;
            end
            S_RESP:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request capture and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            wr_q    <= 1'b0;
            dir_q   <= '0;
            paddr_q <= '0;
            flags_q <= '0;
            fault_q <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q <= req_vaddr;
                        wr_q <= req_write;
                        if (!paging_en) begin
                            paddr_q <= req_vaddr;
                            flags_q <= '0;
                            fault_q <= 1'b0;
                        end else if (lk_hit) begin
                            fault_q <= chk_fault;
                            paddr_q <= chk_fault ? '0 :
                                       {lk_data.ppn, req_vaddr[OFF_W-1:0]};
                            flags_q <= chk_fault ? '0 : lk_data.flags;
                        end
                    end
                end
                S_DIR_WAIT: begin
                    if (mem_rd_valid) begin
                        dir_q <= mem_rd_data[VA_W-1:OFF_W];
                        if (!mem_rd_data[0]) begin
                            fault_q <= 1'b1;
                            paddr_q <= '0;
                            flags_q <= '0;
                        end
                    end
                end
                S_PTE_WAIT: begin
                    if (mem_rd_valid) begin
                        fault_q <= chk_fault;
                        paddr_q <= chk_fault ? '0 :
                                   {mem_rd_data[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
                        flags_q <= chk_fault ? '0 : mem_rd_data[FLAG_W:1];
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        mem_rd_req  = 1'b0;
        mem_rd_addr = '0;
        rsp_valid   = 1'b0;
        fill_en     = 1'b0;
        unique case (state_q)
            S_IDLE:     req_ready = 1'b1;
            S_DIR_REQ: begin
                mem_rd_req  = 1'b1;
                mem_rd_addr = dir_addr;
            end
            S_PTE_REQ: begin
                mem_rd_req  = 1'b1;
                mem_rd_addr = pte_addr;
            end
            S_PTE_WAIT: fill_en = mem_rd_valid && mem_rd_data[0];
            S_RESP:     rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign fill_vpn  = va_q[VA_W-1:OFF_W];
    assign fill_data = '{ppn: mem_rd_data[VA_W-1:OFF_W], flags: mem_rd_data[FLAG_W:1]};
    assign rsp_paddr = paddr_q;
    assign rsp_flags = flags_q;
    assign rsp_fault = fault_q;
    assign rsp_write = wr_q;

    AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_valid && paging_en && lk_hit)
        |=> (rsp_valid && !mem_rd_req)); // R8

    AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_valid && !paging_en)
        |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr))); // R7

    AST_DIR_ABSENT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DIR_WAIT && mem_rd_valid && !mem_rd_data[0])
        |=> (rsp_valid && rsp_fault && !mem_rd_req)); // R2

    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_flags == '0)); // R12

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12

    AST_ONE_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req); // R3
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int TLB_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic [31:0]       dir_base,
    input  logic              flush_all,
    input  logic              flush_one,
    input  logic [19:0]       flush_vpn,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    output logic              mem_rd_req,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              rsp_valid,
    output logic [31:0]       rsp_paddr,
    output logic [7:0]        rsp_flags,
    output logic              rsp_fault,
    output logic              rsp_write
);
    logic             lk_hit;
    tlb_data_t        lk_data;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    tlb_data_t        fill_data;

    ptw_tlb #(.ENTRIES(TLB_ENTRIES)) i_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (req_vaddr[VA_W-1:OFF_W]),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_data (fill_data),
        .flush_all (flush_all),
        .flush_one (flush_one),
        .flush_vpn (flush_vpn)
    );

    ptw_walk i_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .paging_en    (paging_en),
        .dir_base     (dir_base),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_write    (req_write),
        .lk_hit       (lk_hit),
        .lk_data      (lk_data),
        .fill_en      (fill_en),
        .fill_vpn     (fill_vpn),
        .fill_data    (fill_data),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .rsp_flags    (rsp_flags),
        .rsp_fault    (rsp_fault),
        .rsp_write    (rsp_write)
    );
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b1;
    logic [31:0] dir_base = 32'h0010_0000;
    logic        flush_all = 1'b0;
    logic        flush_one = 1'b0;
    logic [19:0] flush_vpn = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [7:0]  rsp_flags;
    logic        rsp_fault;
    logic        rsp_write;

    always #2 clk = ~clk;   // 250 MHz

    pt_walker i_pt_walker (.*);

    int checks = 0;
    int fails = 0;
    int reads = 0;

    // memory model: answers two cycles after the strobe
    logic [31:0] mem [logic [31:0]];
    logic [31:0] pend_addr = '0;
    int          pend_cnt = 0;

    function automatic logic [31:0] mem_get(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (pend_cnt != 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem_get(pend_addr);
            end
        end
        if (mem_rd_req) begin
            pend_addr <= mem_rd_addr;
            pend_cnt  <= 2;
            reads     <= reads + 1;
        end
    end

    typedef struct {
        logic [31:0] pa;
        logic [7:0]  fl;
        logic        ft;
        logic        wr;
        string       tag;
    } exp_t;
    exp_t exq[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exq.size() == 0) begin
                chk(1'b0, "R12", "unexpected response", rsp_paddr, 32'h0);
            end else begin
                exp_t e;
                e = exq.pop_front();
                chk(rsp_paddr == e.pa, e.tag, "paddr", rsp_paddr, e.pa);
                chk(rsp_flags == e.fl, e.tag, "flags", {24'h0, rsp_flags}, {24'h0, e.fl});
                chk(rsp_fault == e.ft, e.tag, "fault", {31'h0, rsp_fault}, {31'h0, e.ft});
                chk(rsp_write == e.wr, e.tag, "write echo", {31'h0, rsp_write}, {31'h0, e.wr});
            end
        end
    end

    // driver: called at a negedge with the walker idle
    task automatic do_req(input logic [31:0] va, input logic wr,
                          input logic [31:0] pa, input logic [7:0] fl, input logic ft,
                          input int exp_reads, input int exp_lat, input string tag);
        int r0;
        int n;
        r0 = reads;
        exq.push_back('{pa: pa, fl: fl, ft: ft, wr: wr, tag: tag});
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(reads - r0 == exp_reads, tag, "memory reads", reads - r0, exp_reads);
        if (exp_lat > 0) chk(n == exp_lat, tag, "latency", n, exp_lat);
        @(negedge clk);
    endtask

    task automatic pulse_flush_one(input logic [19:0] vpn);
        flush_vpn = vpn;
        flush_one = 1'b1;
        @(negedge clk);
        flush_one = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        mem[32'h0010_0004] = 32'h0020_0001;  // directory entry 1
        mem[32'h0020_000C] = 32'h1234_5007;  // page A: R+W
        mem[32'h0020_0010] = 32'hABCD_E1A3;  // page B: R only, flags D1
        mem[32'h0020_0018] = 32'h5555_5005;  // page E: W only
        mem[32'h0020_001C] = 32'h6666_6003;  // page F
        mem[32'h0020_0020] = 32'h7777_7003;  // page G

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R12", "reset req_ready", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R12", "reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk(mem_rd_req == 1'b0, "R12", "reset mem_rd_req", {31'h0, mem_rd_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // walks and hits
        do_req(32'h0040_3123, 1'b0, 32'h1234_5123, 8'h03, 1'b0, 2, 0, "R1_R3_R5");
        do_req(32'h0040_3FF0, 1'b0, 32'h1234_5FF0, 8'h03, 1'b0, 0, 1, "R8");
        do_req(32'h0040_3004, 1'b1, 32'h1234_5004, 8'h03, 1'b0, 0, 1, "R8");
        do_req(32'h0040_4010, 1'b1, 32'h0, 8'h00, 1'b1, 2, 0, "R6");
        do_req(32'h0040_4010, 1'b0, 32'hABCD_E010, 8'hD1, 1'b0, 0, 1, "R8");
        do_req(32'h0080_0000, 1'b0, 32'h0, 8'h00, 1'b1, 1, 0, "R2");
        do_req(32'h0040_5000, 1'b1, 32'h0, 8'h00, 1'b1, 2, 0, "R4");
        do_req(32'h0040_6008, 1'b0, 32'h0, 8'h00, 1'b1, 2, 0, "R6");

        // round robin: [A,B,E,-] -> F, G evicts A
        do_req(32'h0040_7000, 1'b0, 32'h6666_6000, 8'h01, 1'b0, 2, 0, "R9");
        do_req(32'h0040_8000, 1'b0, 32'h7777_7000, 8'h01, 1'b0, 2, 0, "R9");
        do_req(32'h0040_3000, 1'b0, 32'h1234_5000, 8'h03, 1'b0, 2, 0, "R9");
        do_req(32'h0040_6100, 1'b1, 32'h5555_5100, 8'h02, 1'b0, 0, 1, "R9");
        do_req(32'h0040_4000, 1'b0, 32'hABCD_E000, 8'hD1, 1'b0, 2, 0, "R9");

        // flush one: table edited, stale copy still hits until flushed
        mem[32'h0020_000C] = 32'h9999_9007;
        do_req(32'h0040_3010, 1'b0, 32'h1234_5010, 8'h03, 1'b0, 0, 1, "R11");
        pulse_flush_one(20'h00403);
        do_req(32'h0040_8004, 1'b0, 32'h7777_7004, 8'h01, 1'b0, 0, 1, "R11");
        do_req(32'h0040_4008, 1'b0, 32'hABCD_E008, 8'hD1, 1'b0, 0, 1, "R11");
        do_req(32'h0040_3010, 1'b0, 32'h9999_9010, 8'h03, 1'b0, 2, 0, "R11");

        // flush all
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        @(negedge clk);
        do_req(32'h0040_3020, 1'b0, 32'h9999_9020, 8'h03, 1'b0, 2, 0, "R10");
        do_req(32'h0040_8020, 1'b0, 32'h7777_7020, 8'h01, 1'b0, 2, 0, "R10");

        // pass-through
        paging_en = 1'b0;
        @(negedge clk);
        do_req(32'h0040_3123, 1'b1, 32'h0040_3123, 8'h00, 1'b0, 0, 1, "R7");
        do_req(32'h0080_0ABC, 1'b0, 32'h0080_0ABC, 8'h00, 1'b0, 0, 1, "R7");

        repeat (4) @(negedge clk);
        chk(exq.size() == 0, "R12", "responses outstanding", exq.size(), 32'h0);
        summary();
        $finish;
    end
endmodule